// File: doc/BRIEF.md
# CRC-8 Barrett Reducer

This block turns a 16-bit folded value into its 8-bit CRC remainder under the generator x^8 + x^2 + x + 1. The CRC is defined as the remainder of V multiplied by x^8 and divided by the generator, taken most significant bit first, with zero initial value and no final inversion. A wide parallel CRC engine that has already reduced many message bytes into one 16-bit folded value places that value here, and this block performs the single closing modulo step.

The reduction contains no bit-serial division. The upper byte of V is first brought down with the constant x^16 mod P. A quotient estimate then comes from carry-less multiplication by the generator's inverse, floor(x^16 / P). Finally that quotient, multiplied by the generator, cancels the upper terms. Every multiplication by a 9-bit constant is split into a shift (the implicit top bit) XORed with an 8-bit carry-less product, so each multiplier takes only byte-wide operands. All three stages are combinational. One register stage sits at the output, so the block accepts a new value on every cycle.

Top module: `crc8_barrett_reducer`

## Requirements
- R1: `resValid` is high in the cycle after a cycle in which `valIn` was sampled high, and low after a cycle in which `valIn` was sampled low.
- R2: When `resValid` is high, `crcOut` equals the remainder of `dataIn`·x^8 divided by 0x107 (x^8+x^2+x+1). Bit 15 of `dataIn` is the highest-order coefficient. The initial value is zero and no output XOR is applied.
- R3: An input of 0xFFFE yields 0x23.
- R4: An input of 0x1137 yields 0xC7.
- R5: Single-term inputs reduce to powers of x: 0x0000 gives 0x00, 0x0001 gives 0x07 (x^8 mod P), and 0x0100 gives 0x15 (x^16 mod P).
- R6: While `valIn` is low, `crcOut` keeps its previous value, whatever is on `dataIn`.
- R7: While `rstN` is low, and right after it rises, `resValid` is 0 and `crcOut` is 0x00.
- R8: Back-to-back inputs on consecutive cycles each produce their own correct result on consecutive cycles, with no bubble.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Active-low synchronous reset |
| valIn | input | 1 | Qualifies `dataIn` in this cycle |
| dataIn | input | 16 | Folded value V to reduce |
| resValid | output | 1 | `crcOut` holds a fresh result |
| crcOut | output | 8 | CRC remainder of V·x^8 mod 0x107 |

## Verification
Single-bit inputs walk each coefficient through the fold, so an error in one constant bit shows up as a wrong power of x. The two known vectors pin down the fold, the quotient estimate and the cancel product, while all-ones and alternating patterns load every partial product at once. Random values, sent back to back with random idle gaps, are compared against a bit-serial long division. This separates a correct quotient from one that fails only when a high-order carry-less term appears, and it shows whether idle cycles leave the held result untouched.

// File: rtl/crc8_barrett_pkg.sv
package crc8_barrett_pkg;

  // Strobes from the control path into the datapath.
  typedef struct packed {
    logic capture;   // load the reduced remainder into the output register
    logic clear;     // force the output register to zero
  } crcStrobes_t;

endpackage

// File: rtl/crc8_barrett_control.sv
module crc8_barrett_control
  import crc8_barrett_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        valIn,
  output crcStrobes_t strobes,
  output logic        resValid
);

  logic validQ;

  always_comb begin
    strobes.clear   = !rstN;
    strobes.capture = rstN && valIn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) validQ <= 1'b0;
    else       validQ <= valIn;
  end

  assign resValid = validQ;

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> (resValid == $past(valIn))); // R1

  AST_ONE_STROBE: assert property (@(posedge clk)
    !(strobes.capture && strobes.clear)); // R7

endmodule

// File: rtl/crc8_barrett_datapath.sv
module crc8_barrett_datapath
  import crc8_barrett_pkg::*;
#(
  parameter int          CRC_W    = 8,
  parameter logic [CRC_W-1:0] POLY_LOW = 8'h07
)(
  input  logic               clk,
  input  logic               rstN,
  input  crcStrobes_t        strobes,
  input  logic [2*CRC_W-1:0] dataIn,
  output logic [CRC_W-1:0]   crcOut
);

  localparam int VAL_W = 2 * CRC_W;
  localparam logic [CRC_W:0] POLY_FULL = {1'b1, POLY_LOW};

  // x^(2W) mod P: moves the upper half of V*x^W down by 2W bit positions.
  function automatic logic [CRC_W-1:0] powModPoly(input int n);
    logic [CRC_W:0] d;
    d = '0;
    d[0] = 1'b1;
    for (int i = 0; i < n; i++) begin
      d = d << 1;
      if (d[CRC_W]) d = d ^ POLY_FULL;
    end
    return d[CRC_W-1:0];
  endfunction

  // floor(x^(2W) / P); its top bit is always set.
  function automatic logic [CRC_W:0] polyInverse();
    logic [CRC_W:0] d;
    logic [CRC_W:0] q;
    d = '0;
    d[0] = 1'b1;
    q = '0;
    for (int i = 0; i < VAL_W; i++) begin
      d = d << 1;
      q = q << 1;
      if (d[CRC_W]) begin
        q[0] = 1'b1;
        d = d ^ POLY_FULL;
      end
    end
    return q;
  endfunction

  function automatic logic [VAL_W-1:0] clMul(input logic [CRC_W-1:0] a,
                                             input logic [CRC_W-1:0] b);
    logic [VAL_W-1:0] r;
    r = '0;
    for (int i = 0; i < CRC_W; i++) begin
      if (b[i]) r = r ^ (VAL_W'(a) << i);
    end
    return r;
  endfunction

  localparam logic [CRC_W-1:0] FOLD_K  = powModPoly(VAL_W);
  localparam logic [CRC_W:0]   INV_FULL = polyInverse();
  localparam logic [CRC_W-1:0] INV_LOW = INV_FULL[CRC_W-1:0];

  // Stage 1: fold the upper byte down.
  logic [CRC_W-1:0] hiPart;
  logic [CRC_W-1:0] loPart;
  logic [VAL_W-1:0] foldProd;
  logic [VAL_W-1:0] uVal;

  always_comb begin
    hiPart   = dataIn[VAL_W-1:CRC_W];
    loPart   = dataIn[CRC_W-1:0];
    foldProd = clMul(hiPart, FOLD_K);
    uVal     = foldProd ^ {loPart, {CRC_W{1'b0}}};
  end

  // Stage 2: quotient estimate; the inverse's top bit becomes a shift.
  logic [CRC_W-1:0] uHi;
  logic [VAL_W-1:0] quotProd;
  logic [CRC_W-1:0] quotEst;

  always_comb begin
    uHi      = uVal[VAL_W-1:CRC_W];
    quotProd = {uHi, {CRC_W{1'b0}}} ^ clMul(uHi, INV_LOW);
    quotEst  = quotProd[VAL_W-1:CRC_W];
  end

  // Stage 3: cancel the upper terms with quotient times polynomial.
  logic [VAL_W-1:0] cancelProd;
  logic [CRC_W-1:0] crcNext;

  always_comb begin
    cancelProd = {quotEst, {CRC_W{1'b0}}} ^ clMul(quotEst, POLY_LOW);
    crcNext    = uVal[CRC_W-1:0] ^ cancelProd[CRC_W-1:0];
  end

  // Output register.
  logic [CRC_W-1:0] crcQ;

  always_ff @(posedge clk) begin
    if (strobes.clear)        crcQ <= '0;
    else if (strobes.capture) crcQ <= crcNext;
  end

  assign crcOut = crcQ;

  // The quotient estimate must cancel the whole upper half exactly.
  AST_UPPER_CANCEL: assert property (@(posedge clk) disable iff (!rstN)
    strobes.capture |-> (cancelProd[VAL_W-1:CRC_W] == uHi)); // R2

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.capture && $past(rstN)) |=> $stable(crcOut)); // R6

  AST_ZERO_IN: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.capture && dataIn == '0) |=> (crcOut == '0)); // R5

  AST_RESET_CLEAR: assert property (@(posedge clk)
    strobes.clear |=> (crcOut == '0)); // R7

endmodule

// File: rtl/crc8_barrett_reducer.sv
module crc8_barrett_reducer
  import crc8_barrett_pkg::*;
#(
  parameter int               CRC_W    = 8,
  parameter logic [CRC_W-1:0] POLY_LOW = 8'h07
)(
  input  logic               clk,
  input  logic               rstN,
  input  logic               valIn,
  input  logic [2*CRC_W-1:0] dataIn,
  output logic               resValid,
  output logic [CRC_W-1:0]   crcOut
);

  crcStrobes_t strobes;

  crc8_barrett_control uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .valIn    (valIn),
    .strobes  (strobes),
    .resValid (resValid)
  );

  crc8_barrett_datapath #(
    .CRC_W    (CRC_W),
    .POLY_LOW (POLY_LOW)
  ) uData (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .dataIn  (dataIn),
    .crcOut  (crcOut)
  );

  AST_KNOWN_VEC: assert property (@(posedge clk) disable iff (!rstN)
    (valIn && dataIn == 16'hFFFE) |=> (crcOut == 8'h23)); // R3

endmodule

// File: tb/tb_crc8_barrett_reducer.sv
module tb_crc8_barrett_reducer;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        valIn = 1'b0;
  logic [15:0] dataIn = '0;
  logic        resValid;
  logic [7:0]  crcOut;

  int nVec = 0;
  int nFail = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  crc8_barrett_reducer dut (
    .clk      (clk),
    .rstN     (rstN),
    .valIn    (valIn),
    .dataIn   (dataIn),
    .resValid (resValid),
    .crcOut   (crcOut)
  );

  // Bit-serial long division of v*x^8 by 0x107.
  function automatic logic [7:0] refCrc(input logic [15:0] v);
    logic [23:0] d;
    d = {v, 8'h00};
    for (int i = 23; i >= 8; i--) begin
      if (d[i]) d[i-:9] = d[i-:9] ^ 9'h107;
    end
    return d[7:0];
  endfunction

  task automatic check(input string req, input logic [7:0] act,
                       input logic [7:0] exp);
    nVec++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive at negedge, result is registered at next posedge, sample at next negedge.
  task automatic sendVec(input string req, input logic [15:0] v);
    valIn  = 1'b1;
    dataIn = v;
    @(negedge clk);
    check({req, " valid"}, {7'b0, resValid}, 8'h01);
    check(req, crcOut, refCrc(v));
  endtask

  task automatic idleCycle(input logic [15:0] junk, input logic [7:0] held);
    valIn  = 1'b0;
    dataIn = junk;
    @(negedge clk);
    check("R1 idle valid", {7'b0, resValid}, 8'h00);
    check("R6 hold", crcOut, held);
  endtask

  initial begin
    int unused;
    logic [7:0] last;
    unused = $urandom(32'd1234);
    repeat (3) @(negedge clk);
    check("R7 reset valid", {7'b0, resValid}, 8'h00);
    check("R7 reset crc", crcOut, 8'h00);
    rstN = 1'b1;
    @(negedge clk);
    check("R7 after reset valid", {7'b0, resValid}, 8'h00);
    check("R7 after reset crc", crcOut, 8'h00);

    sendVec("R3", 16'hFFFE);
    check("R3 known", crcOut, 8'h23);
    sendVec("R4", 16'h1137);
    check("R4 known", crcOut, 8'hC7);
    sendVec("R5 zero", 16'h0000);
    check("R5 zero", crcOut, 8'h00);
    sendVec("R5 x8", 16'h0001);
    check("R5 x8", crcOut, 8'h07);
    sendVec("R5 x16", 16'h0100);
    check("R5 x16", crcOut, 8'h15);

    for (int b = 0; b < 16; b++) sendVec("R2 walk", 16'h1 << b);
    sendVec("R2 ones", 16'hFFFF);
    sendVec("R2 alt", 16'hAAAA);
    sendVec("R2 alt2", 16'h5555);
    last = refCrc(16'h5555);
    idleCycle(16'h1234, last);
    idleCycle(16'hFFFF, last);

    // R8: back-to-back random, with random idle gaps.
    for (int n = 0; n < 400; n++) begin
      logic [15:0] v;
      v = 16'($urandom);
      sendVec("R8 random", v);
      if (($urandom % 4) == 0) idleCycle(16'($urandom), refCrc(v));
    end

    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", nVec, nFail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  == %0d vectors applied, %0d miscompares ==", nVec, nFail);
      $finish;
    end
  end

endmodule